// File: doc/BRIEF.md
# Signed 6x6 Dadda Tree Multiplier

This block multiplies two 6-bit two's-complement operands and returns the exact 12-bit two's-complement product. It builds a 6-by-6 array of bit products. The sign-weighted bits are formed with NAND instead of AND, and two constant ones (at weights 2^6 and 2^11) make the result exact. The array then goes through a Dadda reduction tree.

The tree has three stages. They cap every column at four bits, then three, then two. It is built from plain half adders, full adders and one half adder variant that adds an extra one. That variant absorbs the 2^6 correction, so no column carries the constant as a separate bit. The two lowest product bits leave the tree directly. The remaining ten columns, two rows of bits, go to a carry-lookahead adder. That adder is built from 4-bit lookahead groups joined by a group-level lookahead.

An optional output register, selected by a parameter and on by default, cuts the timing path. It uses a synchronous active-low reset.

Top module: `dadda_mul6`

## Requirements
- R1: For every pair of 6-bit signed operands, `p` equals their signed product taken to 12 bits.
- R2: Operands 6'h20 and 6'h20 (-32 times -32) give 12'h400 (+1024), with no overflow or sign flip.
- R3: With the output register on, the product of the operands sampled at a rising edge appears after that edge and holds until the next edge. A low `rst_n` at a rising edge sets `p` to zero, whatever the operands are.
- R4: Bit 0 of `p` equals `a[0] & b[0]`.
- R5: Whenever the product is nonzero, bit 11 of `p` is set exactly when `a[5]` and `b[5]` differ.
- R6: If either operand is zero, `p` is zero.
- R7: If one operand is +1, `p` is the other operand sign-extended to 12 bits. If one operand is -1, `p` is the other operand negated, so -32 gives +32.
- R8: Read as a signed number, `p` always lies within -992 to +1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | 6 | Multiplicand, two's complement |
| b | input | 6 | Multiplier, two's complement |
| p | output | 12 | Signed product, two's complement |

## Verification
The bench applies all 4096 operand pairs and checks each result against a signed multiply computed arithmetically. This covers the most-negative square, where a design that dropped the 2^11 correction constant would report -1024 instead of +1024. It also covers the sign-weighted rows, where a misplaced NAND bit or a special half adder used as a plain one would give results that are off by a power of two for mixed-sign pairs. Before each clock edge the bench checks that the output still holds the previous product, which exposes a register bypassed or loaded a cycle early. A reset asserted while -32 times -32 is presented must still clear the output.

// File: rtl/dd_pkg.sv
`timescale 1ns/1ps
// Package: shared widths for the signed Dadda multiplier.
// Assumes a fixed 6-bit operand size; the tree wiring in the top depends on it.
package dd_pkg;
    localparam int OPW    = 6;          // operand width
    localparam int PRW    = 2 * OPW;    // product width
    localparam int LSB_DIRECT = 2;      // low product bits taken straight from the tree
    localparam int CPAW   = PRW - LSB_DIRECT; // width of the final carry-lookahead adder
    localparam int CLA_GW = 4;          // lookahead group size
endpackage

// File: rtl/dd_ha.sv
`timescale 1ns/1ps
// Module: dd_ha
// Two-input counter cell. With PLUS_ONE clear it is a plain half adder.
// With PLUS_ONE set it returns x + y + 1, which folds a constant one into
// the column without spending a bit position on it.
// Assumes: the x + y + 1 result never exceeds 3, so two outputs suffice.
module dd_ha #(
    parameter bit PLUS_ONE = 1'b0
) (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);
    generate
        if (PLUS_ONE) begin : g_plus
            // sum of x + y + 1: inverted parity, carry when either input is set
            assign s = ~(x ^ y);
            assign c = x | y;
        end else begin : g_plain
            // sum of x + y
            assign s = x ^ y;
            assign c = x & y;
        end
    endgenerate
endmodule

// File: rtl/dd_fa.sv
`timescale 1ns/1ps
// Module: dd_fa
// Full adder: counts three bits of one column. The sum stays in that
// column and the carry goes to the next more significant column.
module dd_fa (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic c
);
    // three-input count
    assign s = x ^ y ^ z;
    assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/dd_cla_grp.sv
`timescale 1ns/1ps
// Module: dd_cla_grp
// One lookahead group of the final adder. Each internal carry is formed as
// a flat sum of generate/propagate products from the group carry-in, not rippled.
// Assumes: GW is small (4 or less) so the flat product terms stay narrow.
module dd_cla_grp #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] x,
    input  logic [GW-1:0] y,
    input  logic          cin,
    output logic [GW-1:0] sum
);
    logic [GW-1:0] prp;
    logic [GW-1:0] cy;

    // lookahead carries per bit, then the sum bits
    always_comb begin
        logic term;
        logic acc;
        prp = x ^ y;
        for (int i = 0; i < GW; i++) begin
            acc = cin;
            for (int j = 0; j < i; j++) acc = acc & prp[j];
            for (int k = 0; k < i; k++) begin
                term = x[k] & y[k];
                for (int j = k + 1; j < i; j++) term = term & prp[j];
                acc = acc | term;
            end
            cy[i] = acc;
        end
        sum = prp ^ cy;
    end
endmodule

// File: rtl/dd_cla.sv
`timescale 1ns/1ps
// Module: dd_cla
// Two-level carry-lookahead adder. W bits are split into groups of GW
// (the last group may be shorter). Group generate/propagate terms feed a
// flat group-level lookahead for each group carry-in. Carry-in is zero and
// the carry-out is dropped (the result is taken modulo 2^W).
module dd_cla #(
    parameter int W  = 10,
    parameter int GW = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    localparam int NG = (W + GW - 1) / GW;

    logic [NG-1:0] cg;    // group carry-ins
    logic [NG-1:0] grp_g; // group generate (top entry unused by design, left zero)
    logic [NG-1:0] grp_p; // group propagate (top entry unused by design, left zero)

    // group generate/propagate for every group that feeds a later one
    always_comb begin
        logic term;
        grp_g = '0;
        grp_p = '0;
        for (int k = 0; k < NG - 1; k++) begin
            grp_p[k] = 1'b1;
            for (int b = 0; b < GW; b++)
                grp_p[k] = grp_p[k] & (x[k*GW+b] ^ y[k*GW+b]);
            for (int b = 0; b < GW; b++) begin
                term = x[k*GW+b] & y[k*GW+b];
                for (int j = b + 1; j < GW; j++)
                    term = term & (x[k*GW+j] ^ y[k*GW+j]);
                grp_g[k] = grp_g[k] | term;
            end
        end
    end

    // flat group-level lookahead for each group carry-in
    always_comb begin
        logic term;
        for (int k = 0; k < NG; k++) begin
            cg[k] = 1'b0;
            for (int m = 0; m < k; m++) begin
                term = grp_g[m];
                for (int j = m + 1; j < k; j++) term = term & grp_p[j];
                cg[k] = cg[k] | term;
            end
        end
    end

    generate
        for (genvar gi = 0; gi < NG; gi++) begin : g_grp
            localparam int LO  = gi * GW;
            localparam int WID = (gi == NG - 1) ? (W - LO) : GW;
            dd_cla_grp #(.GW(WID)) u_grp (
                .x   (x[LO +: WID]),
                .y   (y[LO +: WID]),
                .cin (cg[gi]),
                .sum (sum[LO +: WID])
            );
        end
    endgenerate
endmodule

// File: rtl/dadda_mul6.sv
`timescale 1ns/1ps
// Module: dadda_mul6
// Signed 6x6 multiplier. The bit products use a sign-corrected array:
// bits pairing exactly one sign bit are NANDed, and constants at weights
// 2^6 and 2^11 make the result exact modulo 2^12. A three-stage Dadda
// tree (column caps 4, 3, 2) reduces the array. A PLUS_ONE half adder
// absorbs the 2^6 constant and the 2^11 constant enters the final row.
// Bits 0 and 1 come straight from the tree, and a 10-bit lookahead adder
// forms bits 11..2. REG_OUT adds one output register with synchronous
// active-low reset.
// Assumes: widths fixed at 6/12 (the tree is hand-placed for them).
module dadda_mul6 #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [dd_pkg::OPW-1:0] a,
    input  logic [dd_pkg::OPW-1:0] b,
    output logic [dd_pkg::PRW-1:0] p
);
    import dd_pkg::*;

    logic [OPW-1:0] pp [OPW];       // pp[i][j] pairs a[i] with b[j], weight 2^(i+j)
    logic [CPAW-1:0] row_x, row_y;  // final two rows, columns 11..2
    logic [CPAW-1:0] cpa_sum;
    logic [PRW-1:0]  prod_c;

    // bit-product array, NAND where exactly one factor is a sign bit
    generate
        for (genvar i = 0; i < OPW; i++) begin : g_row
            for (genvar j = 0; j < OPW; j++) begin : g_col
                if ((i == OPW - 1) != (j == OPW - 1)) begin : g_nand
                    assign pp[i][j] = ~(a[i] & b[j]);
                end else begin : g_and
                    assign pp[i][j] = a[i] & b[j];
                end
            end
        end
    endgenerate

    // ---- stage 1: cap every column at four bits ----
    logic h1a_s, h1a_c, h1b_s, h1b_c, x1_s, x1_c;
    logic f1a_s, f1a_c, f1b_s, f1b_c, f1c_s, f1c_c;
    dd_ha #(.PLUS_ONE(1'b0)) u_h1a (.x(pp[0][4]), .y(pp[1][3]), .s(h1a_s), .c(h1a_c));
    dd_fa u_f1a (.x(pp[0][5]), .y(pp[1][4]), .z(pp[2][3]), .s(f1a_s), .c(f1a_c));
    dd_ha #(.PLUS_ONE(1'b0)) u_h1b (.x(pp[3][2]), .y(pp[4][1]), .s(h1b_s), .c(h1b_c));
    dd_fa u_f1b (.x(pp[1][5]), .y(pp[2][4]), .z(pp[3][3]), .s(f1b_s), .c(f1b_c));
    dd_ha #(.PLUS_ONE(1'b1)) u_x1  (.x(pp[4][2]), .y(pp[5][1]), .s(x1_s),  .c(x1_c));
    dd_fa u_f1c (.x(pp[2][5]), .y(pp[3][4]), .z(pp[4][3]), .s(f1c_s), .c(f1c_c));

    // ---- stage 2: cap every column at three bits ----
    logic h2a_s, h2a_c;
    logic f2a_s, f2a_c, f2b_s, f2b_c, f2c_s, f2c_c, f2d_s, f2d_c, f2e_s, f2e_c;
    dd_ha #(.PLUS_ONE(1'b0)) u_h2a (.x(pp[0][3]), .y(pp[1][2]), .s(h2a_s), .c(h2a_c));
    dd_fa u_f2a (.x(h1a_s),    .y(pp[2][2]), .z(pp[3][1]), .s(f2a_s), .c(f2a_c));
    dd_fa u_f2b (.x(f1a_s),    .y(h1b_s),    .z(pp[5][0]), .s(f2b_s), .c(f2b_c));
    dd_fa u_f2c (.x(f1b_s),    .y(x1_s),     .z(f1a_c),    .s(f2c_s), .c(f2c_c));
    dd_fa u_f2d (.x(f1c_s),    .y(pp[5][2]), .z(f1b_c),    .s(f2d_s), .c(f2d_c));
    dd_fa u_f2e (.x(pp[3][5]), .y(pp[4][4]), .z(pp[5][3]), .s(f2e_s), .c(f2e_c));

    // ---- stage 3: cap every column at two bits ----
    logic h3a_s, h3a_c;
    logic f3a_s, f3a_c, f3b_s, f3b_c, f3c_s, f3c_c, f3d_s, f3d_c;
    logic f3e_s, f3e_c, f3f_s, f3f_c, f3g_s, f3g_c, f3h_s, f3h_c;
    dd_ha #(.PLUS_ONE(1'b0)) u_h3a (.x(pp[0][1]), .y(pp[1][0]), .s(h3a_s), .c(h3a_c));
    dd_fa u_f3a (.x(pp[0][2]), .y(pp[1][1]), .z(pp[2][0]), .s(f3a_s), .c(f3a_c));
    dd_fa u_f3b (.x(h2a_s),    .y(pp[2][1]), .z(pp[3][0]), .s(f3b_s), .c(f3b_c));
    dd_fa u_f3c (.x(f2a_s),    .y(pp[4][0]), .z(h2a_c),    .s(f3c_s), .c(f3c_c));
    dd_fa u_f3d (.x(f2b_s),    .y(h1a_c),    .z(f2a_c),    .s(f3d_s), .c(f3d_c));
    dd_fa u_f3e (.x(f2c_s),    .y(h1b_c),    .z(f2b_c),    .s(f3e_s), .c(f3e_c));
    dd_fa u_f3f (.x(f2d_s),    .y(x1_c),     .z(f2c_c),    .s(f3f_s), .c(f3f_c));
    dd_fa u_f3g (.x(f2e_s),    .y(f1c_c),    .z(f2d_c),    .s(f3g_s), .c(f3g_c));
    dd_fa u_f3h (.x(pp[4][5]), .y(pp[5][4]), .z(f2e_c),    .s(f3h_s), .c(f3h_c));

    // final rows for columns 11..2; the 2^11 correction rides in row_y
    assign row_x = {1'b0, pp[5][5], f3h_s, f3g_s, f3f_s, f3e_s, f3d_s, f3c_s, f3b_s, f3a_s};
    assign row_y = {1'b1, f3h_c, f3g_c, f3f_c, f3e_c, f3d_c, f3c_c, f3b_c, f3a_c, h3a_c};

    dd_cla #(.W(CPAW), .GW(CLA_GW)) u_cla (.x(row_x), .y(row_y), .sum(cpa_sum));

    assign prod_c = {cpa_sum, h3a_s, pp[0][0]};

    generate
        if (REG_OUT) begin : g_reg
            logic [PRW-1:0] p_q;
            // output register, synchronous active-low clear
            always_ff @(posedge clk) begin
                if (!rst_n) p_q <= '0;
                else        p_q <= prod_c;
            end
            assign p = p_q;
        end else begin : g_comb
            assign p = prod_c;
        end
    endgenerate
endmodule

// File: rtl/dd_mul_chk.sv
`timescale 1ns/1ps
// Module: dd_mul_chk
// Property checker for dadda_mul6, attached with bind. It compares the
// output with a behavioural signed multiply of the operands (one cycle
// earlier when the output register is on).
module dd_mul_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  a,
    input logic [5:0]  b,
    input logic [11:0] p
);
    logic [11:0] ref_prod;

    // behavioural signed product, sign-extended to 12 bits
    always_comb ref_prod = $signed({{6{a[5]}}, a}) * $signed({{6{b[5]}}, b});

    generate
        if (REG_OUT) begin : g_seq
            AST_PRODUCT:     assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> p == $past(ref_prod)); // R1
            AST_MIN_SQUARE:  assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(a) == 6'h20 && $past(b) == 6'h20) |-> p == 12'h400); // R2
            AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !$past(rst_n) |-> p == 12'h000); // R3
            AST_LSB:         assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> p[0] == ($past(a[0]) & $past(b[0]))); // R4
            AST_SIGN:        assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && p != 12'h000) |-> p[11] == ($past(a[5]) ^ $past(b[5]))); // R5
            AST_ZERO:        assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && ($past(a) == 6'h00 || $past(b) == 6'h00)) |-> p == 12'h000); // R6
            AST_RANGE:       assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> ($signed(p) >= -992 && $signed(p) <= 1024)); // R8
        end else begin : g_cmb
            AST_PRODUCT:     assert property (@(posedge clk) disable iff (!rst_n) p == ref_prod); // R1
            AST_LSB:         assert property (@(posedge clk) disable iff (!rst_n) p[0] == (a[0] & b[0])); // R4
            AST_RANGE:       assert property (@(posedge clk) disable iff (!rst_n) ($signed(p) >= -992 && $signed(p) <= 1024)); // R8
        end
    endgenerate
endmodule

bind dadda_mul6 dd_mul_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .p     (p)
);

// File: tb/sim_dadda_mul6.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of all operand pairs against an arithmetic signed
// product, plus reset and register-timing checks.
module sim_dadda_mul6;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  a = '0;
    logic [5:0]  b = '0;
    logic [11:0] p;

    int errs = 0;
    int chks = 0;

    dadda_mul6 #(.REG_OUT(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p));

    // 250 MHz clock
    always #2 clk = ~clk;

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        chks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: a=%h b=%h got %h expected %h", req, a, b, got, exp);
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        #(4 * 200000);
        errs++;
        chks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        logic [11:0] prev;
        logic [11:0] exp;
        string       lab;
        int          sa, sb, pv;

        // R3: reset state with nonzero operands present
        a = 6'h15;
        b = 6'h2A;
        repeat (3) @(negedge clk);
        check("R3 reset clears", p, 12'h000);
        rst_n = 1'b1;
        prev = 12'h000;

        for (int ia = 0; ia < 64; ia++) begin
            for (int ib = 0; ib < 64; ib++) begin
                a = ia[5:0];
                b = ib[5:0];
                sa = (ia >= 32) ? ia - 64 : ia;
                sb = (ib >= 32) ? ib - 64 : ib;
                exp = 12'(sa * sb);
                #1;
                check("R3 holds before edge", p, prev);
                @(negedge clk);
                if (sa == -32 && sb == -32)                       lab = "R2 min square";
                else if (sa == 0 || sb == 0)                      lab = "R6 zero operand";
                else if (sa == 1 || sa == -1 || sb == 1 || sb == -1) lab = "R7 unit operand";
                else                                              lab = "R1 product";
                check(lab, p, exp);
                check("R4 lsb", {11'b0, p[0]}, {11'b0, a[0] & b[0]});
                if (exp != 12'h000)
                    check("R5 sign", {11'b0, p[11]}, {11'b0, (sa < 0) != (sb < 0)});
                pv = $signed(p);
                check("R8 range", {11'b0, (pv >= -992 && pv <= 1024)}, 12'h001);
                prev = exp;
            end
        end

        // R3: reset wins over -32 x -32 at the same edge
        a = 6'h20;
        b = 6'h20;
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 reset over operands", p, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 min square after reset", p, 12'h400);

        // R7: -1 times -32 gives +32
        a = 6'h3F;
        b = 6'h20;
        @(negedge clk);
        check("R7 negate most negative", p, 12'h020);

        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule